// File: doc/BRIEF.md
# USB/PS2 Port Control Register

This block is one 8-bit control and status register for a pin pair that can act as a low-speed USB port or as a PS/2 port. Software reaches it through a plain register bus: an address, a write strobe, write data and combinational read data. The register enables the PS/2 pull-ups and the 3.3 V regulator, and it selects which kind of line activity raises the port interrupt. It also keeps a sticky bus-activity flag, which the serial interface engine sets with a one-cycle pulse and software clears by writing 0.

The low three bits form a forcing code. Code 000 hands both pads to the serial engine. Codes 001 to 011 drive the USB line states in push-pull. Codes 100 to 111 give open-drain drive, where each pin is either pulled low or left floating. Each pad has its own output-enable and output-data signal. An optional output stage, chosen by a parameter, can register the pad controls.

Top module: `usbps2_port_ctl`

## Requirements
- R1: After reset every register bit reads 0, every pad output-enable is 0 and the pull-up, regulator and interrupt-mode outputs are 0.
- R2: A write with `reg_addr == REG_ADDR` (default 0x1F) stores bit 7 (pull-up enable), bit 6 (regulator enable), bit 5 (interrupt mode) and bits 2:0 (forcing code), and a read at that address returns them in the same positions in the cycle after the write edge. Writes to any other address change nothing, and reads at any other address return 0.
- R3: Bit 4 is reserved. It always reads 0 and writes to it are ignored.
- R4: A one-cycle `sie_activity` pulse sets bit 3 (bus activity). The bit reads 1 from the next cycle on.
- R5: Writing 0 to bit 3 clears it. Writing 1 to bit 3 leaves it unchanged, and only the serial engine can set it.
- R6: If an activity pulse and a clearing write fall in the same cycle, bit 3 ends up at 1.
- R7: With forcing code 000, each pad output-enable and output-data equals the matching `sie_*` input.
- R8: Code 001 drives K (D+ 1, D− 0), code 010 drives J (D+ 0, D− 1) and code 011 drives SE0 (both 0). Both pads are enabled in all three codes.
- R9: Codes 1xx are open-drain. 100 pulls both pins low, 101 pulls D− low and floats D+, 110 floats D− and pulls D+ low, and 111 floats both. A floating pin has output-enable 0 and data 0. No pin is ever driven high in these codes.
- R10: `ps2_pullup_en` = bit 7 OR `dev_addr_en`. `vreg_en` = bit 6. `irq_ps2_sel` = bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| sie_activity | input | 1 | One-cycle bus-activity pulse from the serial engine |
| dev_addr_en | input | 1 | Device-address-enabled indication, also turns on the pull-ups |
| sie_dp_oe | input | 1 | Serial engine D+ output-enable |
| sie_dp_o | input | 1 | Serial engine D+ data |
| sie_dm_oe | input | 1 | Serial engine D− output-enable |
| sie_dm_o | input | 1 | Serial engine D− data |
| dp_oe | output | 1 | D+ pad output-enable |
| dp_o | output | 1 | D+ pad data |
| dm_oe | output | 1 | D− pad output-enable |
| dm_o | output | 1 | D− pad data |
| ps2_pullup_en | output | 1 | PS/2 pull-up enable |
| vreg_en | output | 1 | Regulator output enable |
| irq_ps2_sel | output | 1 | Interrupt mode: 1 selects PS/2 activity, 0 selects USB bus reset |

## Verification
With the default combinational pad stage, a write takes effect on the clock edge that samples it. The stored fields, the read data, the pull-up, regulator and mode outputs, and the decoded pad controls are therefore all due in the cycle that follows the edge. An activity pulse shows up in bit 3 one edge later. Pass-through pads and `dev_addr_en` have no clock delay. The bench changes inputs on the falling clock edge and samples results on the next falling edge. Pass-through and pull-up checks are sampled after a short delay in the same low phase.

// File: rtl/usbps2_pkg.sv
package usbps2_pkg;

   localparam int unsigned CTL_W    = 8;
   localparam int unsigned PU_BIT   = 7;
   localparam int unsigned VREG_BIT = 6;
   localparam int unsigned IRQ_BIT  = 5;
   localparam int unsigned RSVD_BIT = 4;
   localparam int unsigned ACT_BIT  = 3;
   localparam int unsigned CODE_W   = 3;

   typedef enum logic [CODE_W-1:0] {
      FC_RELEASE = 3'b000,
      FC_K       = 3'b001,
      FC_J       = 3'b010,
      FC_SE0     = 3'b011,
      FC_OD_LL   = 3'b100,
      FC_OD_ZL   = 3'b101,
      FC_OD_LZ   = 3'b110,
      FC_OD_ZZ   = 3'b111
   } force_code_e;

   typedef struct packed {
      logic oe;
      logic o;
   } pad_ctl_t;

   typedef struct packed {
      logic              pu;
      logic              vreg;
      logic              irq_sel;
      logic              act;
      logic [CODE_W-1:0] code;
   } ctl_fields_t;

endpackage

// File: rtl/usbps2_ctl_regs.sv
module usbps2_ctl_regs
   import usbps2_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hit_i,
   input  logic [CTL_W-1:0]    wdata_i,
   input  logic                sie_act_i,
   output ctl_fields_t         fields_o
);

   ctl_fields_t fld_q;
   logic        unused_rsvd;

   assign unused_rsvd = wdata_i[RSVD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q <= '0;
      end else begin
         if (wr_hit_i) begin
            fld_q.pu      <= wdata_i[PU_BIT];
            fld_q.vreg    <= wdata_i[VREG_BIT];
            fld_q.irq_sel <= wdata_i[IRQ_BIT];
            fld_q.code    <= wdata_i[CODE_W-1:0];
         end
         if (sie_act_i) begin
            fld_q.act <= 1'b1;
         end else if (wr_hit_i && !wdata_i[ACT_BIT]) begin
            fld_q.act <= 1'b0;
         end
      end
   end

   assign fields_o = fld_q;

   // R4
   act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sie_act_i |=> fld_q.act);

   // R5
   act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit_i && !wdata_i[ACT_BIT] && !sie_act_i) |=> !fld_q.act);

   // R5
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sie_act_i && !(wr_hit_i && !wdata_i[ACT_BIT])) |=> $stable(fld_q.act));

endmodule

// File: rtl/usbps2_force_decode.sv
module usbps2_force_decode
   import usbps2_pkg::*;
#(
   parameter int unsigned PAD_STAGE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  pad_ctl_t          sie_dp_i,
   input  pad_ctl_t          sie_dm_i,
   output pad_ctl_t          dp_o,
   output pad_ctl_t          dm_o
);

   localparam pad_ctl_t DRV_HI = '{oe: 1'b1, o: 1'b1};
   localparam pad_ctl_t DRV_LO = '{oe: 1'b1, o: 1'b0};
   localparam pad_ctl_t FLOAT  = '{oe: 1'b0, o: 1'b0};

   if (PAD_STAGE > 1) begin : g_bad_stage
      $error("PAD_STAGE must be 0 or 1");
   end

   pad_ctl_t dp_d, dm_d;

   always_comb begin
      dp_d = FLOAT;
      dm_d = FLOAT;
      unique case (force_code_e'(code_i))
         FC_RELEASE: begin dp_d = sie_dp_i; dm_d = sie_dm_i; end
         FC_K:       begin dp_d = DRV_HI;   dm_d = DRV_LO;   end
         FC_J:       begin dp_d = DRV_LO;   dm_d = DRV_HI;   end
         FC_SE0:     begin dp_d = DRV_LO;   dm_d = DRV_LO;   end
         FC_OD_LL:   begin dp_d = DRV_LO;   dm_d = DRV_LO;   end
         FC_OD_ZL:   begin dp_d = FLOAT;    dm_d = DRV_LO;   end
         FC_OD_LZ:   begin dp_d = DRV_LO;   dm_d = FLOAT;    end
         FC_OD_ZZ:   begin dp_d = FLOAT;    dm_d = FLOAT;    end
         default:    begin dp_d = FLOAT;    dm_d = FLOAT;    end
      endcase
   end

   if (PAD_STAGE == 0) begin : g_comb
      assign dp_o = dp_d;
      assign dm_o = dm_d;
   end else begin : g_reg
      pad_ctl_t dp_q, dm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dp_q <= FLOAT;
            dm_q <= FLOAT;
         end else begin
            dp_q <= dp_d;
            dm_q <= dm_d;
         end
      end
      assign dp_o = dp_q;
      assign dm_o = dm_q;
   end

   // R9
   od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_i[CODE_W-1] |-> (!(dp_d.oe && dp_d.o) && !(dm_d.oe && dm_d.o)));

   // R8
   forced_not_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i != '0) |-> !(dp_d.oe && dp_d.o && dm_d.oe && dm_d.o));

endmodule

// File: rtl/usbps2_port_ctl.sv
module usbps2_port_ctl
   import usbps2_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned REG_ADDR  = 8'h1F,
   parameter int unsigned PAD_STAGE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              sie_activity,
   input  logic              dev_addr_en,
   input  logic              sie_dp_oe,
   input  logic              sie_dp_o,
   input  logic              sie_dm_oe,
   input  logic              sie_dm_o,
   output logic              dp_oe,
   output logic              dp_o,
   output logic              dm_oe,
   output logic              dm_o,
   output logic              ps2_pullup_en,
   output logic              vreg_en,
   output logic              irq_ps2_sel
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (ADDR_W < 32 && REG_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("REG_ADDR does not fit in ADDR_W");
   end

   logic        addr_hit;
   logic        wr_hit;
   ctl_fields_t fld;
   pad_ctl_t    sie_dp, sie_dm, pad_dp, pad_dm;

   assign addr_hit = (reg_addr == HIT_ADDR);
   assign wr_hit   = reg_wr && addr_hit;

   usbps2_ctl_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit_i  (wr_hit),
      .wdata_i   (reg_wdata),
      .sie_act_i (sie_activity),
      .fields_o  (fld)
   );

   assign sie_dp = '{oe: sie_dp_oe, o: sie_dp_o};
   assign sie_dm = '{oe: sie_dm_oe, o: sie_dm_o};

   usbps2_force_decode #(.PAD_STAGE(PAD_STAGE)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_i   (fld.code),
      .sie_dp_i (sie_dp),
      .sie_dm_i (sie_dm),
      .dp_o     (pad_dp),
      .dm_o     (pad_dm)
   );

   assign dp_oe = pad_dp.oe;
   assign dp_o  = pad_dp.o;
   assign dm_oe = pad_dm.oe;
   assign dm_o  = pad_dm.o;

   assign ps2_pullup_en = fld.pu || dev_addr_en;
   assign vreg_en       = fld.vreg;
   assign irq_ps2_sel   = fld.irq_sel;

   always_comb begin
      reg_rdata = '0;
      if (addr_hit) begin
         reg_rdata[PU_BIT]           = fld.pu;
         reg_rdata[VREG_BIT]         = fld.vreg;
         reg_rdata[IRQ_BIT]          = fld.irq_sel;
         reg_rdata[ACT_BIT]          = fld.act;
         reg_rdata[CODE_W-1:0]       = fld.code;
      end
   end

   // R2
   foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !addr_hit) |=> $stable(fld.code) && $stable(fld.pu));

   // R6
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sie_activity && wr_hit && !reg_wdata[ACT_BIT]) |=> fld.act);

endmodule

// File: tb/usbps2_port_ctl_tb.sv
module usbps2_port_ctl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = 8'h1F;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sie_activity = 1'b0, dev_addr_en = 1'b0;
   logic       sie_dp_oe = 1'b0, sie_dp_o = 1'b0, sie_dm_oe = 1'b0, sie_dm_o = 1'b0;
   logic       dp_oe, dp_o, dm_oe, dm_o, ps2_pullup_en, vreg_en, irq_ps2_sel;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   usbps2_port_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sie_activity(sie_activity), .dev_addr_en(dev_addr_en),
      .sie_dp_oe(sie_dp_oe), .sie_dp_o(sie_dp_o),
      .sie_dm_oe(sie_dm_oe), .sie_dm_o(sie_dm_o),
      .dp_oe(dp_oe), .dp_o(dp_o), .dm_oe(dm_oe), .dm_o(dm_o),
      .ps2_pullup_en(ps2_pullup_en), .vreg_en(vreg_en), .irq_ps2_sel(irq_ps2_sel)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic act_pulse);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1; sie_activity = act_pulse;
      @(negedge clk);
      reg_wr = 1'b0; sie_activity = 1'b0; reg_addr = 8'h1F;
      #0.5;
   endtask

   // expected {dp_oe,dp_o,dm_oe,dm_o}
   function automatic logic [3:0] pads_exp(input logic [2:0] c, input logic [3:0] s);
      case (c)
         3'd0: return s;
         3'd1: return 4'b1110;
         3'd2: return 4'b1011;
         3'd3: return 4'b1010;
         3'd4: return 4'b1010;
         3'd5: return 4'b0010;
         3'd6: return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata", reg_rdata, 8'h00);
      check("R1 outputs", {1'b0, dp_oe, dm_oe, ps2_pullup_en, vreg_en, irq_ps2_sel, 2'b0}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: sweep all write values, no activity so bit 3 stays 0
      for (int v = 0; v < 256; v++) begin
         wr(8'h1F, 8'(v), 1'b0);
         check("R2/R3 readback", reg_rdata, 8'(v) & 8'hE7);
         check("R10 outputs", {5'b0, vreg_en, irq_ps2_sel, 1'b0},
               {5'b0, 1'(v >> 6), 1'(v >> 5), 1'b0});
      end

      // R2: foreign address write ignored, foreign read is 0
      wr(8'h1F, 8'hA2, 1'b0);
      wr(8'h1E, 8'h45, 1'b0);
      check("R2 foreign write", reg_rdata, 8'hA2);
      reg_addr = 8'h00; #0.5;
      check("R2 foreign read", reg_rdata, 8'h00);
      reg_addr = 8'h1F; #0.5;

      // R4: activity pulse sets bit 3 one edge later
      @(negedge clk); sie_activity = 1'b1;
      @(negedge clk); sie_activity = 1'b0;
      check("R4 set", reg_rdata & 8'h08, 8'h08);
      // R5: write 1 preserves
      wr(8'h1F, 8'h08, 1'b0);
      check("R5 write1 keeps", reg_rdata, 8'h08);
      // R5: write 0 clears
      wr(8'h1F, 8'h00, 1'b0);
      check("R5 write0 clears", reg_rdata, 8'h00);
      // R5: write 1 never sets
      wr(8'h1F, 8'h08, 1'b0);
      check("R5 write1 no set", reg_rdata, 8'h00);
      // R6: set beats clear in same cycle
      wr(8'h1F, 8'h01, 1'b1);
      check("R6 set wins", reg_rdata, 8'h09);
      wr(8'h1F, 8'h00, 1'b0);

      // R7 R8 R9: all codes x all serial engine patterns
      for (int c = 0; c < 8; c++) begin
         wr(8'h1F, 8'(c), 1'b0);
         for (int s = 0; s < 16; s++) begin
            {sie_dp_oe, sie_dp_o, sie_dm_oe, sie_dm_o} = 4'(s);
            #0.5;
            check(c == 0 ? "R7 pass" : (c < 4 ? "R8 push-pull" : "R9 open-drain"),
                  {4'b0, dp_oe, dp_o, dm_oe, dm_o},
                  {4'b0, pads_exp(3'(c), 4'(s))});
         end
      end

      // R10: pull-up OR with device address enable
      for (int p = 0; p < 4; p++) begin
         wr(8'h1F, p[1] ? 8'h80 : 8'h00, 1'b0);
         dev_addr_en = p[0];
         #0.5;
         check("R10 pullup", {7'b0, ps2_pullup_en}, {7'b0, p[1] | p[0]});
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule